// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Retention Lockout

This controller moves a small processor core between running, an idle state and four sleep variants. A save request from the core, qualified by a deep-select line, picks idle or sleep. Two control bits, retention and fast wake, together with a non-volatile permit bit, pick the sleep flavour. Idle halts only the CPU clock and clears the watchdog. Ordinary sleep and retention sleep both end through a settling window whose length is set by parameters. The window stands in for regulator recovery.

Retention sleep first passes through a lockout window timed by a slow oscillator. The oscillator's tick is brought into the controller clock domain by a two-flop synchroniser and a rising-edge detector. During lockout only a power-on or external reset can end the sleep. Interrupts and watchdog timeouts in that window are dropped, not held. After lockout a wake source must newly assert. A wake-cause register reports which source ended the last low-power stay.

States: `ST_RUN`, `ST_IDLE`, `ST_SLEEP`, `ST_LOCK` (retention lockout), `ST_RSLEEP` (retention sleep after lockout), `ST_SETTLE`. Transitions: RUN→IDLE (save request, deep_sel=0); RUN→SLEEP (save request, deep_sel=1, retention not selected); RUN→LOCK (save request, deep_sel=1, retention selected); IDLE→RUN (any wake source or deferred interrupt); SLEEP→SETTLE (any wake source or deferred interrupt); LOCK→SETTLE (power-on or external reset); LOCK→RSLEEP (lockout expiry); RSLEEP→SETTLE (reset, watchdog, or newly rising interrupt); SETTLE→RUN (settle count done).

Top module: `lpm_sequencer`

## Requirements
- R1: After reset the state is ST_RUN: cpu_clk_en=1 and wdog_clr, ret_reg_sel, bg_en and wake are all 0. wake_cause=0 (none).
- R2: While in ST_RUN, a save request with deep_sel=0 drops cpu_clk_en on the next cycle. It also raises wdog_clr for exactly that one cycle.
- R3: In idle, a power-on reset, an external reset, a watchdog timeout or any bit of irq restores cpu_clk_en on the next cycle. wake is 1 for that one cycle, and no settling delay is inserted.
- R4: An interrupt present in the same cycle as a save request for idle or ordinary sleep does not stop the entry. It wakes the block in the first cycle of the low-power state, with cause 1.
- R5: A sleep request picks retention (ret_reg_sel=1 while sleeping) only when ret_ctl=1 and ret_permit_n=0. Any other combination gives ordinary sleep with ret_reg_sel=0.
- R6: bg_en equals the fast_ctl value sampled at the request, during sleep, lockout, retention sleep and settling. It is 0 in run and idle.
- R7: Retention lockout ends after 1 synchronised slow-oscillator rising edge if slow_osc_on was 1 at the request. Otherwise it ends after 2+OSC_START edges.
- R8: During lockout, irq and watchdog timeouts have no effect and are not remembered. This includes an interrupt coincident with the request. An irq held high across expiry does not wake. Power-on or external reset leaves lockout for settling.
- R9: After lockout, retention sleep ends on a reset, a watchdog timeout, or an irq bit that rises while in retention sleep.
- R10: From a sleep exit the block stays in settling with cpu_clk_en=0 for D cycles. D is SLEEP_DLY for ordinary sleep and RET_DLY for retention, minus FAST_CUT when fast_ctl was 1. It then returns to run with cpu_clk_en=1 and wake=1 for one cycle.
- R11: wake_cause is loaded at each wake with the highest-priority active source. The codes are power-on reset 4, external reset 3, watchdog 2, interrupt 1. It is cleared to 0 by the next save request.
- R12: The slow oscillator advances lockout only on a rising edge seen after two synchronising flops. A level held high counts once.
- R13: Save requests made outside ST_RUN are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Power-save request from the core (one cycle) |
| deep_sel | input | 1 | 1 = sleep, 0 = idle |
| ret_ctl | input | 1 | Retention enable control bit |
| fast_ctl | input | 1 | Fast-wake control bit (band-gap on) |
| ret_permit_n | input | 1 | Non-volatile retention permit, 0 = permitted |
| irq | input | IRQ_W | Individually enabled interrupt requests |
| wdog_expire | input | 1 | Watchdog timeout |
| ext_rst_evt | input | 1 | External reset event |
| por_evt | input | 1 | Power-on reset event |
| slow_osc | input | 1 | Slow oscillator clock, asynchronous |
| slow_osc_on | input | 1 | Slow oscillator already running |
| cpu_clk_en | output | 1 | CPU clock enable |
| wdog_clr | output | 1 | One-cycle watchdog clear |
| ret_reg_sel | output | 1 | Retention regulator select |
| bg_en | output | 1 | Band-gap enable |
| wake | output | 1 | One-cycle wake event on return to run |
| wake_cause | output | 3 | Source of the last wake |

## Verification
The bench builds the block with IRQ_W=4, SLEEP_DLY=3, RET_DLY=7, FAST_CUT=2 and OSC_START=1. The short settle counts let every sleep-exit path return to run within a few dozen cycles. OSC_START=1 makes the cold-oscillator lockout three edges long, so an interrupt can be placed between edges and shown to be lost. It also lets a held-high tick be shown to count only once before expiry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_LOCK   = 3'd3,
        ST_RSLEEP = 3'd4,
        ST_SETTLE = 3'd5
    } lpm_state_e;

    typedef enum logic [2:0] {
        WC_NONE = 3'd0,
        WC_IRQ  = 3'd1,
        WC_WDT  = 3'd2,
        WC_EXT  = 3'd3,
        WC_POR  = 3'd4
    } wake_cause_e;

    // Highest-priority source; interrupt is assumed when nothing else is set.
    function automatic wake_cause_e pick_cause(logic p, logic e, logic w);
        if (p) return WC_POR;
        if (e) return WC_EXT;
        if (w) return WC_WDT;
        return WC_IRQ;
    endfunction

endpackage

// File: rtl/lpm_tick_sync.sv
module lpm_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);
    logic [2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], tick_async};
    end

    assign tick_pulse = sh_q[1] & ~sh_q[2];

    // R12
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/lpm_lockout.sv
module lpm_lockout #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    input  logic          step,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (load)                       cnt_q <= load_val;
        else if (run && step && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expire = run && step && (cnt_q == CW'(1));

    // R7
    lockout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load) |=> (cnt_q == '0));

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int IRQ_W     = 8,
    parameter int SLEEP_DLY = 4,
    parameter int RET_DLY   = 12,
    parameter int FAST_CUT  = 3,
    parameter int OSC_START = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             save_req,
    input  logic             deep_sel,
    input  logic             ret_ctl,
    input  logic             fast_ctl,
    input  logic             ret_permit_n,
    input  logic [IRQ_W-1:0] irq,
    input  logic             wdog_expire,
    input  logic             ext_rst_evt,
    input  logic             por_evt,
    input  logic             slow_osc,
    input  logic             slow_osc_on,
    output logic             cpu_clk_en,
    output logic             wdog_clr,
    output logic             ret_reg_sel,
    output logic             bg_en,
    output logic             wake,
    output logic [2:0]       wake_cause
);
    // Settle counts must satisfy SLEEP_DLY > FAST_CUT and RET_DLY > SLEEP_DLY.
    localparam int DLY_W    = $clog2(RET_DLY + 1);
    localparam int LOCK_MAX = 2 + OSC_START;
    localparam int LOCK_W   = $clog2(LOCK_MAX + 1);
    localparam logic [DLY_W-1:0] DL_SLP  = DLY_W'(SLEEP_DLY - 1);
    localparam logic [DLY_W-1:0] DL_SLPF = DLY_W'(SLEEP_DLY - FAST_CUT - 1);
    localparam logic [DLY_W-1:0] DL_RET  = DLY_W'(RET_DLY - 1);
    localparam logic [DLY_W-1:0] DL_RETF = DLY_W'(RET_DLY - FAST_CUT - 1);

    lpm_state_e       state_q, state_d;
    wake_cause_e      cause_q, cause_d;
    logic [DLY_W-1:0] cnt_q, dly_sel;
    logic [IRQ_W-1:0] irq_q;
    logic             pend_q, ret_q, fast_q, wake_q, wclr_q;
    logic             wake_d, wclr_d, take_cause, clear_cause, cnt_load, lock_load;
    logic             tick_p, lock_expire;
    logic             rst_ev, irq_any, irq_rise, lp_wake, rs_wake, ret_sel;
    logic [LOCK_W-1:0] lock_need;

    lpm_tick_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (slow_osc),
        .tick_pulse (tick_p)
    );

    lpm_lockout #(.CW(LOCK_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load),
        .load_val (lock_need),
        .run      (state_q == ST_LOCK),
        .step     (tick_p),
        .expire   (lock_expire)
    );

    assign rst_ev    = por_evt | ext_rst_evt;
    assign irq_any   = |irq;
    assign irq_rise  = |(irq & ~irq_q);
    assign lp_wake   = rst_ev | wdog_expire | irq_any | pend_q;
    assign rs_wake   = rst_ev | wdog_expire | irq_rise;
    assign ret_sel   = ret_ctl & ~ret_permit_n;
    assign lock_need = slow_osc_on ? LOCK_W'(1) : LOCK_W'(LOCK_MAX);

    always_comb begin
        unique case ({ret_q, fast_q})
            2'b00:   dly_sel = DL_SLP;
            2'b01:   dly_sel = DL_SLPF;
            2'b10:   dly_sel = DL_RET;
            default: dly_sel = DL_RETF;
        endcase
    end

    // Next-state and transition decode
    always_comb begin
        state_d     = state_q;
        cause_d     = pick_cause(por_evt, ext_rst_evt, wdog_expire);
        take_cause  = 1'b0;
        clear_cause = 1'b0;
        cnt_load    = 1'b0;
        lock_load   = 1'b0;
        wake_d      = 1'b0;
        wclr_d      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (save_req) begin
                    clear_cause = 1'b1;
                    if (!deep_sel) begin
                        state_d = ST_IDLE;
                        wclr_d  = 1'b1;
                    end else if (ret_sel) begin
                        state_d   = ST_LOCK;
                        lock_load = 1'b1;
                    end else begin
                        state_d = ST_SLEEP;
                    end
                end
            end
            ST_IDLE: begin
                if (lp_wake) begin
                    state_d    = ST_RUN;
                    take_cause = 1'b1;
                    wake_d     = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (lp_wake) begin
                    state_d    = ST_SETTLE;
                    take_cause = 1'b1;
                    cnt_load   = 1'b1;
                end
            end
            ST_LOCK: begin
                if (rst_ev) begin
                    state_d    = ST_SETTLE;
                    take_cause = 1'b1;
                    cnt_load   = 1'b1;
                end else if (lock_expire) begin
                    state_d = ST_RSLEEP;
                end
            end
            ST_RSLEEP: begin
                if (rs_wake) begin
                    state_d    = ST_SETTLE;
                    take_cause = 1'b1;
                    cnt_load   = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == '0) begin
                    state_d = ST_RUN;
                    wake_d  = 1'b1;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Datapath and registered pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= WC_NONE;
            cnt_q   <= '0;
            irq_q   <= '0;
            pend_q  <= 1'b0;
            ret_q   <= 1'b0;
            fast_q  <= 1'b0;
            wake_q  <= 1'b0;
            wclr_q  <= 1'b0;
        end else begin
            irq_q  <= irq;
            wake_q <= wake_d;
            wclr_q <= wclr_d;
            if (clear_cause) begin
                cause_q <= WC_NONE;
                ret_q   <= deep_sel & ret_sel;
                fast_q  <= fast_ctl;
                pend_q  <= irq_any & ~(deep_sel & ret_sel);
            end else if (take_cause) begin
                cause_q <= cause_d;
                pend_q  <= 1'b0;
            end
            if (cnt_load)
                cnt_q <= dly_sel;
            else if (state_q == ST_SETTLE && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        cpu_clk_en  = (state_q == ST_RUN);
        ret_reg_sel = (state_q == ST_LOCK) || (state_q == ST_RSLEEP);
        bg_en       = fast_q && (state_q == ST_SLEEP || state_q == ST_LOCK ||
                                 state_q == ST_RSLEEP || state_q == ST_SETTLE);
        wake        = wake_q;
        wdog_clr    = wclr_q;
        wake_cause  = cause_q;
    end

    // R2
    wdog_clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_clr |-> !cpu_clk_en);
    // R3
    idle_fast_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && lp_wake) |=> (cpu_clk_en && wake));
    // R8
    lock_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !rst_ev) |=> (!cpu_clk_en && state_q != ST_SETTLE));
    // R10
    wake_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> cpu_clk_en);
    // R5
    ret_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_reg_sel) |-> $past(save_req && deep_sel && ret_ctl && !ret_permit_n));
    // R11
    cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && save_req) |=> (wake_cause == 3'd0));

endmodule

// File: tb/lpm_sequencer_test.sv
module lpm_sequencer_test;
    localparam int IRQ_W = 4, SLP = 3, RET = 7, CUT = 2, OSTART = 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, save_req, deep_sel, ret_ctl, fast_ctl, ret_permit_n;
    logic wdog_expire, ext_rst_evt, por_evt, slow_osc, slow_osc_on;
    logic [IRQ_W-1:0] irq;
    logic cpu_clk_en, wdog_clr, ret_reg_sel, bg_en, wake;
    logic [2:0] wake_cause;

    lpm_sequencer #(.IRQ_W(IRQ_W), .SLEEP_DLY(SLP), .RET_DLY(RET),
                    .FAST_CUT(CUT), .OSC_START(OSTART)) uut (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .deep_sel(deep_sel),
        .ret_ctl(ret_ctl), .fast_ctl(fast_ctl), .ret_permit_n(ret_permit_n),
        .irq(irq), .wdog_expire(wdog_expire), .ext_rst_evt(ext_rst_evt),
        .por_evt(por_evt), .slow_osc(slow_osc), .slow_osc_on(slow_osc_on),
        .cpu_clk_en(cpu_clk_en), .wdog_clr(wdog_clr), .ret_reg_sel(ret_reg_sel),
        .bg_en(bg_en), .wake(wake), .wake_cause(wake_cause));

    int compared = 0, mismatched = 0;
    string tag = "R1";
    bit done = 1'b0;

    // Behavioural reference: 0 run, 1 idle, 2 sleep, 3 lockout, 4 ret sleep, 5 settle
    int ms = 0, mcnt = 0, mlock = 0, mcause = 0;
    bit mpend = 0, mret = 0, mfast = 0, mwake = 0, mwclr = 0;
    bit t1 = 0, t2 = 0, t3 = 0;
    logic [IRQ_W-1:0] mirq_q = '0;

    function automatic int prio(bit p, bit e, bit w);
        if (p) return 4;
        if (e) return 3;
        if (w) return 2;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms = 0; mcnt = 0; mlock = 0; mcause = 0;
            mpend = 0; mret = 0; mfast = 0; mwake = 0; mwclr = 0;
            t1 = 0; t2 = 0; t3 = 0; mirq_q = '0;
        end else begin
            bit tp, any, rise, rsel, rst_e, w_lp, w_rs;
            tp    = t2 && !t3;
            t3    = t2; t2 = t1; t1 = slow_osc;
            any   = (irq != 0);
            rise  = ((irq & ~mirq_q) != 0);
            mirq_q = irq;
            rst_e = por_evt || ext_rst_evt;
            rsel  = ret_ctl && !ret_permit_n;
            w_lp  = rst_e || wdog_expire || any || mpend;
            w_rs  = rst_e || wdog_expire || rise;
            mwake = 0; mwclr = 0;
            case (ms)
                0: if (save_req) begin
                       mcause = 0; mfast = fast_ctl;
                       mret = deep_sel && rsel;
                       mpend = any && !(deep_sel && rsel);
                       if (!deep_sel) begin ms = 1; mwclr = 1; end
                       else if (rsel) begin ms = 3; mlock = slow_osc_on ? 1 : 2 + OSTART; end
                       else ms = 2;
                   end
                1: if (w_lp) begin
                       mcause = prio(por_evt, ext_rst_evt, wdog_expire);
                       mpend = 0; ms = 0; mwake = 1;
                   end
                2: if (w_lp) begin
                       mcause = prio(por_evt, ext_rst_evt, wdog_expire);
                       mpend = 0; ms = 5;
                       mcnt = (mret ? RET : SLP) - (mfast ? CUT : 0) - 1;
                   end
                3: if (rst_e) begin
                       mcause = prio(por_evt, ext_rst_evt, 1'b0);
                       mpend = 0; ms = 5;
                       mcnt = RET - (mfast ? CUT : 0) - 1;
                   end else if (tp) begin
                       if (mlock == 1) ms = 4;
                       mlock = mlock - 1;
                   end
                4: if (w_rs) begin
                       mcause = prio(por_evt, ext_rst_evt, wdog_expire);
                       mpend = 0; ms = 5;
                       mcnt = RET - (mfast ? CUT : 0) - 1;
                   end
                default: if (mcnt == 0) begin ms = 0; mwake = 1; end
                         else mcnt = mcnt - 1;
            endcase
        end
    end

    task automatic chk(string nm, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("cpu_clk_en", cpu_clk_en, ms == 0);
            chk("wdog_clr", wdog_clr, mwclr);
            chk("ret_reg_sel", ret_reg_sel, ms == 3 || ms == 4);
            chk("bg_en", bg_en, mfast && ms >= 2);
            chk("wake", wake, mwake);
            chk("wake_cause", wake_cause, mcause);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic req(bit deep);
        save_req = 1'b1; deep_sel = deep;
        cyc(1);
        save_req = 1'b0;
    endtask

    task automatic tick_edge();
        slow_osc = 1'b1; cyc(3);
        slow_osc = 1'b0; cyc(3);
    endtask

    task automatic pulse_irq(logic [IRQ_W-1:0] v);
        irq = v; cyc(1); irq = '0;
    endtask

    task automatic pulse_wdt();
        wdog_expire = 1'b1; cyc(1); wdog_expire = 1'b0;
    endtask

    initial begin
        rst_n = 0; save_req = 0; deep_sel = 0; ret_ctl = 0; fast_ctl = 0;
        ret_permit_n = 0; irq = '0; wdog_expire = 0; ext_rst_evt = 0;
        por_evt = 0; slow_osc = 0; slow_osc_on = 0;
        cyc(3); rst_n = 1;
        tag = "R1";  cyc(3);
        tag = "R2";  req(0); cyc(3);
        tag = "R3";  pulse_irq(4'b0010); cyc(2);
        req(0); cyc(2); pulse_wdt(); cyc(2);
        req(0); cyc(2); ext_rst_evt = 1; cyc(1); ext_rst_evt = 0; cyc(2);
        tag = "R11"; req(0); cyc(1); por_evt = 1; wdog_expire = 1; cyc(1);
        por_evt = 0; wdog_expire = 0; cyc(2);
        tag = "R4";  irq = 4'b1000; req(0); irq = '0; cyc(4);
        irq = 4'b0100; req(1); irq = '0; cyc(8);
        tag = "R5";  ret_ctl = 1; ret_permit_n = 1; req(1); cyc(3); pulse_wdt(); cyc(6);
        ret_ctl = 0; ret_permit_n = 0; req(1); cyc(3); pulse_wdt(); cyc(6);
        tag = "R6";  fast_ctl = 1; req(1); cyc(3); pulse_irq(4'b0001); cyc(5); fast_ctl = 0;
        tag = "R8";  ret_ctl = 1; slow_osc_on = 1; irq = 4'b0100; req(1); cyc(2);
        tick_edge(); cyc(4); irq = '0; cyc(2);
        tag = "R9";  pulse_irq(4'b0001); cyc(10);
        tag = "R7";  slow_osc_on = 0; req(1); cyc(2); tick_edge();
        pulse_irq(4'b0010); tick_edge(); pulse_wdt(); tick_edge(); cyc(2);
        pulse_wdt(); cyc(10);
        tag = "R8";  req(1); cyc(2); pulse_irq(4'b1000);
        ext_rst_evt = 1; cyc(1); ext_rst_evt = 0; cyc(10);
        tag = "R12"; req(1); cyc(1); slow_osc = 1; cyc(10);
        pulse_irq(4'b0001); cyc(2); slow_osc = 0; cyc(3);
        tick_edge(); tick_edge(); pulse_irq(4'b0010); cyc(10);
        tag = "R13"; ret_ctl = 0; req(1); cyc(2); pulse_wdt();
        save_req = 1; deep_sel = 0; cyc(2); save_req = 0; cyc(6);
        req(0); save_req = 1; cyc(1); save_req = 0; pulse_irq(4'b0001); cyc(3);
        tag = "R10"; ret_ctl = 1; fast_ctl = 1; slow_osc_on = 1; req(1);
        tick_edge(); cyc(2); pulse_irq(4'b0100); cyc(10);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++; mismatched++;
            $display("FAIL R13 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule